// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block supplies the two source operands of the instruction sitting in the register-read stage of an eight-stage in-order integer pipeline. The stages after register read are decode (s4), execute (s5), commit (s6) and writeback (s7), plus a pseudo-stage s8 that keeps the writeback result for one more cycle. The block keeps its own shadow copy of the destination descriptor of every instruction in s4 to s8. For each source register it searches those descriptors and picks the result of the youngest matching producer. When nothing matches, it passes on the register-file value.

Results are tapped at four positions. The execute-stage ALU result is at s5, the commit-stage result (ALU or load data) is at s6 and the writeback result is at s7. The s8 hold register is internal to the block. It exists because the register file's read data, presented in s3, was sampled one cycle earlier. That sample cannot see a write that happened in s7 during the previous cycle.

A result that is not computed yet raises a hold on the front of the pipeline. An ALU result does not exist while its producer is still in s4. A load result does not exist while its producer is in s4 or s5. While the hold is raised, s0 to s3 keep their contents, a bubble enters s4, and s5 to s8 keep advancing.

Top module: `opnd_bypass`

## Requirements
- R1: While reset is asserted and after it is released, no stage from s4 to s8 holds a producer. `hold_front` is 0 and each operand equals its register-file input, for any nonzero source index.
- R2: A source index that matches no valid writing producer in s4 to s8 yields the register-file value.
- R3: Source index 0 always yields operand 0, never raises the hold, and is never matched, even by an instruction whose destination index is 0 and which is marked as writing.
- R4: A matching producer yields its tapped result. The tap is `ex_result` for s5 (ALU only), `cm_result` for s6, `wb_result` for s7, and the value `wb_result` carried in the cycle before for s8.
- R5: When several stages hold the same destination, the youngest producer (the lowest stage number) supplies the operand.
- R6: A stage takes part only if its valid bit is set and its write flag is 1. A source whose enable is 0 never raises the hold.
- R7: An enabled source whose youngest producer is an ALU instruction in s4 raises `hold_front` for exactly one cycle.
- R8: An enabled source whose youngest producer is a load raises `hold_front` for two cycles when the load is in s4 and for one cycle when it is in s5. Load data comes from s6 onward. The hold is never high for more than two consecutive cycles.
- R9: While held, the consumer stays in s3 and a bubble (a non-valid descriptor) enters s4. After the hold drops, the consumer receives the correct value.
- R10: `hold_front` is 0 whenever `cons_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cons_valid | input | 1 | Instruction present in s3 |
| cons_rs1 | input | 5 | First source index |
| cons_rs1_en | input | 1 | First source is read |
| cons_rs2 | input | 5 | Second source index |
| cons_rs2_en | input | 1 | Second source is read |
| cons_rd | input | 5 | Destination index of the s3 instruction |
| cons_wr | input | 1 | s3 instruction writes a register |
| cons_load | input | 1 | s3 instruction is a load |
| regf_data1 | input | XLEN | Register-file read data for source 1 |
| regf_data2 | input | XLEN | Register-file read data for source 2 |
| ex_result | input | XLEN | ALU result of the s5 instruction |
| cm_result | input | XLEN | Result (ALU or load) of the s6 instruction |
| wb_result | input | XLEN | Result of the s7 instruction |
| opnd1 | output | XLEN | Forwarded first operand |
| opnd2 | output | XLEN | Forwarded second operand |
| hold_front | output | 1 | Hold s0 to s3 and insert a bubble into s4 |

## Verification
Forwarding and the interlock can act in the same cycle. One source can be held by a young producer while the other source already has a ready match in a later stage. Once the hold drops, the youngest of two producers of the same register must win over an older one. The bench provokes these cases with a directed pair of back-to-back writes to one register and a load followed by its immediate use. It also uses a random stream confined to eight registers, so that matches in several stages are frequent. Every operand that is issued is judged against a sequential reference register array. Every cycle's hold is judged against the stall computed from the bench's own stage model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // register index width (32 architectural registers)
  localparam int unsigned REG_AW = 5;
  // producer positions tracked: s4, s5, s6, s7, s8
  localparam int unsigned NPROD = 5;
  // tapped results: s5, s6, s7, s8
  localparam int unsigned NTAP = NPROD - 1;
  // first tracked position (0 = s4) at which each result kind is ready
  localparam int unsigned ALU_RDY = 1;
  localparam int unsigned LD_RDY  = 2;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic              load;
    logic [REG_AW-1:0] rd;
  } prod_t;
endpackage

// File: rtl/fwd_track.sv
module fwd_track
  import fwd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic                    hold,
  input  logic [REG_AW-1:0]       issue_rd,
  input  logic                    issue_wr,
  input  logic                    issue_load,
  input  logic [XLEN-1:0]         wb_result,
  output prod_t [NPROD-1:0]       prods,
  output logic  [XLEN-1:0]        s8_data
);

  prod_t [NPROD-1:0] stg_q;
  prod_t [NPROD-1:0] stg_d;
  logic [XLEN-1:0]   s8_q;
  logic              s8_en;

  // next state: s4 takes the issuing instruction or a bubble
  always_comb begin
    stg_d[0] = '0;
    if (issue_valid && !hold) begin
      stg_d[0].valid = 1'b1;
      stg_d[0].wr    = issue_wr;
      stg_d[0].load  = issue_load;
      stg_d[0].rd    = issue_rd;
    end
  end

  // later positions always advance
  genvar g;
  generate
    for (g = 1; g < NPROD; g++) begin : g_shift
      assign stg_d[g] = stg_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  // s8 keeps the writeback result one more cycle
  assign s8_en = stg_q[NPROD-2].valid && stg_q[NPROD-2].wr;

  always_ff @(posedge clk) begin
    if (s8_en) s8_q <= wb_result;
  end

  assign prods   = stg_q;
  assign s8_data = s8_q;

  // R9
  bubble_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !stg_q[0].valid);

endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REG_AW-1:0]       rs,
  input  logic                    rs_en,
  input  logic [XLEN-1:0]         rf_data,
  input  prod_t [NPROD-1:0]       prods,
  input  logic  [NTAP-1:0][XLEN-1:0] taps,
  output logic [XLEN-1:0]         opnd,
  output logic                    need_wait
);

  logic [NPROD-1:0] match;
  logic [XLEN-1:0]  chain_data [NPROD+1];
  logic             chain_wait [NPROD+1];
  logic             rs_zero;

  assign rs_zero = (rs == '0);
  assign chain_data[NPROD] = rf_data;
  assign chain_wait[NPROD] = 1'b0;

  // priority chain: the oldest position is at the tail, the youngest wins
  genvar g;
  generate
    for (g = 0; g < NPROD; g++) begin : g_pos
      assign match[g] = prods[g].valid && prods[g].wr &&
                        (prods[g].rd == rs) && !rs_zero;
      if (g == 0) begin : g_notap
        assign chain_data[g] = match[g] ? rf_data : chain_data[g+1];
      end else begin : g_tap
        assign chain_data[g] = match[g] ? taps[g-1] : chain_data[g+1];
      end
      assign chain_wait[g] = match[g]
        ? (prods[g].load ? (g < LD_RDY) : (g < ALU_RDY))
        : chain_wait[g+1];
    end
  endgenerate

  always_comb begin
    opnd      = rs_zero ? '0 : chain_data[0];
    need_wait = rs_en && chain_wait[0];
  end

  // R3
  zero_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_zero |-> (opnd == '0) && !need_wait);

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import fwd_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cons_valid,
  input  logic [REG_AW-1:0] cons_rs1,
  input  logic              cons_rs1_en,
  input  logic [REG_AW-1:0] cons_rs2,
  input  logic              cons_rs2_en,
  input  logic [REG_AW-1:0] cons_rd,
  input  logic              cons_wr,
  input  logic              cons_load,
  input  logic [XLEN-1:0]   regf_data1,
  input  logic [XLEN-1:0]   regf_data2,
  input  logic [XLEN-1:0]   ex_result,
  input  logic [XLEN-1:0]   cm_result,
  input  logic [XLEN-1:0]   wb_result,
  output logic [XLEN-1:0]   opnd1,
  output logic [XLEN-1:0]   opnd2,
  output logic              hold_front
);

  localparam int unsigned NSRC = 2;

  prod_t [NPROD-1:0]          prods;
  logic  [XLEN-1:0]           s8_data;
  logic  [NTAP-1:0][XLEN-1:0] taps;
  logic  [REG_AW-1:0]         src_idx  [NSRC];
  logic                       src_en   [NSRC];
  logic  [XLEN-1:0]           src_rf   [NSRC];
  logic  [XLEN-1:0]           src_val  [NSRC];
  logic  [NSRC-1:0]           src_wait;
  logic                       hold_w;

  assign src_idx[0] = cons_rs1;
  assign src_idx[1] = cons_rs2;
  assign src_en[0]  = cons_rs1_en;
  assign src_en[1]  = cons_rs2_en;
  assign src_rf[0]  = regf_data1;
  assign src_rf[1]  = regf_data2;

  // tap order follows the tracked positions s5, s6, s7, s8
  assign taps[0] = ex_result;
  assign taps[1] = cm_result;
  assign taps[2] = wb_result;
  assign taps[3] = s8_data;

  fwd_track #(.XLEN(XLEN)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(cons_valid),
    .hold       (hold_w),
    .issue_rd   (cons_rd),
    .issue_wr   (cons_wr),
    .issue_load (cons_load),
    .wb_result  (wb_result),
    .prods      (prods),
    .s8_data    (s8_data)
  );

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      fwd_select #(.XLEN(XLEN)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rs       (src_idx[s]),
        .rs_en    (src_en[s]),
        .rf_data  (src_rf[s]),
        .prods    (prods),
        .taps     (taps),
        .opnd     (src_val[s]),
        .need_wait(src_wait[s])
      );
    end
  endgenerate

  always_comb begin
    hold_w = cons_valid && (|src_wait);
  end

  assign hold_front = hold_w;
  assign opnd1      = src_val[0];
  assign opnd2      = src_val[1];

  // R10
  hold_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |-> cons_valid);

  // R8
  hold_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front && $past(hold_front) |=> !hold_front);

endmodule

// File: tb/opnd_bypass_test.sv
`timescale 1ns/1ps
module opnd_bypass_test;

  typedef struct packed {
    logic        v, wr, ld, e1, e2, stl;
    logic [4:0]  rd, rs1, rs2;
    logic [31:0] imm, res;
  } ins_t;

  localparam logic [31:0] X0_JUNK = 32'hBAD0_0BAD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cons_valid, cons_rs1_en, cons_rs2_en, cons_wr, cons_load;
  logic [4:0]  cons_rs1, cons_rs2, cons_rd;
  logic [31:0] regf_data1, regf_data2, ex_result, cm_result, wb_result;
  logic [31:0] opnd1, opnd2;
  logic        hold_front;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dir_k = 0;
  bit done = 0;

  ins_t p2, p3, p4, p5, p6, p7, p8;
  logic [31:0] rf [32];
  logic [31:0] ref_rf [32];
  logic [31:0] rd1_q, rd2_q;

  always #5 clk = ~clk;

  opnd_bypass uut (
    .clk(clk), .rst_n(rst_n),
    .cons_valid(cons_valid), .cons_rs1(cons_rs1), .cons_rs1_en(cons_rs1_en),
    .cons_rs2(cons_rs2), .cons_rs2_en(cons_rs2_en), .cons_rd(cons_rd),
    .cons_wr(cons_wr), .cons_load(cons_load),
    .regf_data1(regf_data1), .regf_data2(regf_data2),
    .ex_result(ex_result), .cm_result(cm_result), .wb_result(wb_result),
    .opnd1(opnd1), .opnd2(opnd2), .hold_front(hold_front)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] ldval(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  function automatic ins_t mk(logic v, logic wr, logic ld, logic e1, logic e2,
                              logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    ins_t t = '0;
    t.v = v; t.wr = wr; t.ld = ld; t.e1 = e1; t.e2 = e2;
    t.rd = rd; t.rs1 = rs1; t.rs2 = rs2;
    t.imm = 32'h0000_0100 * {27'd0, rd} + 32'h13;
    return t;
  endfunction

  // directed stream followed by constrained random instructions
  function automatic ins_t next_ins();
    ins_t t;
    if (dir_k < 16) begin
      case (dir_k)
        0:  t = mk(1, 1, 0, 1, 1, 5'd1, 5'd2, 5'd3); // ALU x1
        1:  t = mk(1, 1, 0, 1, 1, 5'd2, 5'd1, 5'd3); // uses x1 at s4 (R7)
        2:  t = mk(1, 1, 1, 1, 0, 5'd4, 5'd1, 5'd0); // load x4
        3:  t = mk(1, 1, 0, 1, 1, 5'd3, 5'd4, 5'd2); // uses x4 at s4 (R8)
        4:  t = mk(1, 1, 1, 1, 0, 5'd5, 5'd3, 5'd0); // load x5
        5:  t = mk(1, 0, 0, 1, 1, 5'd5, 5'd6, 5'd7); // no write, rd=x5 (R6)
        6:  t = mk(1, 1, 0, 1, 1, 5'd6, 5'd5, 5'd5); // x5 load at s5 (R8)
        7:  t = mk(1, 1, 0, 1, 1, 5'd6, 5'd2, 5'd3); // x6 again
        8:  t = mk(1, 1, 0, 1, 1, 5'd7, 5'd6, 5'd1); // youngest x6 (R5)
        9:  t = mk(1, 1, 0, 1, 1, 5'd0, 5'd3, 5'd4); // writes x0
        10: t = mk(1, 1, 0, 1, 1, 5'd2, 5'd0, 5'd0); // reads x0 (R3)
        11: t = mk(0, 1, 0, 1, 1, 5'd7, 5'd1, 5'd1); // invalid rd=x7 (R6)
        12: t = mk(1, 1, 0, 1, 1, 5'd1, 5'd7, 5'd2); // x7 from older
        13: t = mk(1, 1, 1, 0, 1, 5'd3, 5'd1, 5'd2); // load, rs1 unused
        14: t = mk(1, 1, 0, 0, 1, 5'd4, 5'd3, 5'd5); // disabled rs1=x3 (R6)
        default: t = mk(1, 1, 0, 1, 1, 5'd5, 5'd4, 5'd1);
      endcase
      dir_k++;
    end else begin
      t = '0;
      t.v   = ($urandom % 100) < 85;
      t.wr  = ($urandom % 100) < 80;
      t.ld  = ($urandom % 100) < 30;
      t.e1  = ($urandom % 100) < 90;
      t.e2  = ($urandom % 100) < 60;
      t.rd  = 5'($urandom % 8);
      t.rs1 = 5'($urandom % 8);
      t.rs2 = 5'($urandom % 8);
      t.imm = $urandom;
    end
    return t;
  endfunction

  function automatic bit hitp(ins_t p, logic [4:0] rs);
    return p.v && p.wr && (p.rd == rs) && (rs != 0);
  endfunction

  function automatic int youngest(logic [4:0] rs);
    if (hitp(p4, rs)) return 4;
    if (hitp(p5, rs)) return 5;
    if (hitp(p6, rs)) return 6;
    if (hitp(p7, rs)) return 7;
    if (hitp(p8, rs)) return 8;
    return 0;
  endfunction

  function automatic int nhits(logic [4:0] rs);
    return int'(hitp(p4, rs)) + int'(hitp(p5, rs)) + int'(hitp(p6, rs)) +
           int'(hitp(p7, rs)) + int'(hitp(p8, rs));
  endfunction

  function automatic bit deadp(ins_t p, logic [4:0] rs);
    return (p.rd == rs) && (rs != 0) && !(p.v && p.wr);
  endfunction

  function automatic bit dead_hit(logic [4:0] rs);
    return deadp(p4, rs) || deadp(p5, rs) || deadp(p6, rs) ||
           deadp(p7, rs) || deadp(p8, rs);
  endfunction

  function automatic bit needs(logic e, logic [4:0] rs);
    int y = youngest(rs);
    return e && (y == 4 || (y == 5 && p5.ld));
  endfunction

  function automatic logic [31:0] rdrf(logic [4:0] a);
    return (a == 0) ? X0_JUNK : rf[a];
  endfunction

  function automatic string otag(ins_t t, logic [4:0] rs);
    if (rs == 0) return "R3";
    if (t.stl) return "R9";
    if (nhits(rs) > 1) return "R5";
    if (nhits(rs) == 1) return "R4";
    if (dead_hit(rs)) return "R6";
    return "R2";
  endfunction

  task automatic drive();
    cons_valid  = p3.v;
    cons_rs1    = p3.rs1;
    cons_rs1_en = p3.e1;
    cons_rs2    = p3.rs2;
    cons_rs2_en = p3.e2;
    cons_rd     = p3.rd;
    cons_wr     = p3.wr;
    cons_load   = p3.ld;
    regf_data1  = rd1_q;
    regf_data2  = rd2_q;
    ex_result   = (p5.v && p5.wr && !p5.ld) ? p5.res : (32'hDEAD_0000 ^ cyc);
    cm_result   = (p6.v && p6.wr) ? p6.res : (32'hC0DE_0000 ^ cyc);
    wb_result   = (p7.v && p7.wr) ? p7.res : (32'hFACE_0000 ^ cyc);
  endtask

  task automatic step();
    ins_t n2, n3, n4;
    logic [31:0] v1, v2, r1, r2;
    bit es;
    string st;
    es = p3.v && (needs(p3.e1, p3.rs1) || needs(p3.e2, p3.rs2));
    if (!p3.v) st = "R10";
    else if (es)
      st = ((youngest(p3.rs1) == 4 && p4.ld && p3.e1) ||
            (youngest(p3.rs2) == 4 && p4.ld && p3.e2) ||
            (youngest(p3.rs1) == 5 && p3.e1) ||
            (youngest(p3.rs2) == 5 && p3.e2)) ? "R8" : "R7";
    else if ((!p3.e1 && youngest(p3.rs1) != 0) || (!p3.e2 && youngest(p3.rs2) != 0) ||
             dead_hit(p3.rs1) || dead_hit(p3.rs2)) st = "R6";
    else st = "R7";
    chk(hold_front == es, st, {31'd0, hold_front}, {31'd0, es});

    if (es) begin
      n3 = p3; n3.stl = 1'b1; n4 = '0; n2 = p2;
    end else begin
      n4 = p3;
      if (p3.v) begin
        v1 = ref_rf[p3.rs1];
        v2 = p3.e2 ? ref_rf[p3.rs2] : 32'd0;
        if (p3.e1) chk(opnd1 == v1, otag(p3, p3.rs1), opnd1, v1);
        if (p3.e2) chk(opnd2 == v2, otag(p3, p3.rs2), opnd2, v2);
        n4.res = p3.ld ? ldval(v1 + p3.imm) : ((v1 + v2) ^ p3.imm);
        if (p3.wr && p3.rd != 0) ref_rf[p3.rd] = n4.res;
      end
      n3 = p2; n3.stl = 1'b0;
      n2 = next_ins();
    end
    r1 = rdrf(n3.rs1);
    r2 = rdrf(n3.rs2);
    if (p7.v && p7.wr && p7.rd != 0) rf[p7.rd] = p7.res;
    p8 = p7; p7 = p6; p6 = p5; p5 = p4; p4 = n4; p3 = n3; p2 = n2;
    rd1_q = r1; rd2_q = r2;
    cyc++;
  endtask

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 32; i++) begin
      rf[i]     = (32'h0101_0101 * i) ^ 32'h11;
      ref_rf[i] = (i == 0) ? 32'd0 : rf[i];
    end
    p2 = '0; p3 = '0; p4 = '0; p5 = '0; p6 = '0; p7 = '0; p8 = '0;
    rd1_q = X0_JUNK; rd2_q = X0_JUNK;
    rst_n = 1'b0;
    // R1: a valid consumer during reset passes register-file data
    cons_valid = 1; cons_rs1 = 5'd3; cons_rs1_en = 1; cons_rs2 = 5'd4;
    cons_rs2_en = 1; cons_rd = 5'd3; cons_wr = 1; cons_load = 1;
    regf_data1 = 32'h1234_5678; regf_data2 = 32'h9ABC_DEF0;
    ex_result = 32'h1; cm_result = 32'h2; wb_result = 32'h3;
    repeat (2) @(negedge clk);
    #1;
    chk(hold_front == 1'b0, "R1", {31'd0, hold_front}, 32'd0);
    chk(opnd1 == 32'h1234_5678, "R1", opnd1, 32'h1234_5678);
    chk(opnd2 == 32'h9ABC_DEF0, "R1", opnd2, 32'h9ABC_DEF0);
    @(negedge clk);
    rst_n = 1'b1;
    drive();
    #1;
    chk(hold_front == 1'b0, "R1", {31'd0, hold_front}, 32'd0);
    p2 = next_ins();
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      drive();
      #1;
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule